// File: doc/BRIEF.md
# Beat-Frequency Phase Estimator with Successive-Approximation Oscillator Tuning

This block locks a numerically controlled oscillator to a beat-frequency reference that has already been filtered, and reports where the oscillator is in its cycle. The oscillator is a 20-bit phase accumulator. It adds a tuning increment on every clock, with one clock per reference sample. The increment lives in a 12-bit window. After a start pulse, a hold timer keeps the loop idle while upstream filter transients die out. The block then aligns to the first rising crossing of the reference and spends twelve reference periods on a most-significant-bit-first binary search for the increment. Each decision depends on whether the oscillator wrapped during the period just ended. After the search, each reference crossing nudges the increment by one count, up or down, according to the phase the accumulator has reached at that crossing.

Each rising crossing of the reference also clears the accumulator, so the accumulator follows the reference phase. A separate capture timer, started by the same pulse, takes a snapshot of the accumulator after a programmed number of clocks and flags the snapshot with a one-clock strobe. A host that wants a phase estimate loads the hold and capture intervals, pulses start, streams samples in, and waits for the strobe.

Top module: `sar_pll_phase_est`

## Requirements
- R1: While reset is held, and until the first start pulse, phase, cap_phase, locked and done all read zero.
- R2: start is sampled at a clock edge. For the next hold_len+1 edges, phase reads zero and every reference sample is ignored. Samples count from the edge after those.
- R3: A rising crossing is a sample that is zero or positive after at least one sample at or below -64 (HYST) since the last crossing. A dip that goes no lower than -63 does not arm a crossing.
- R4: While the loop runs, a crossing clears phase to zero at that edge. At every other edge, phase advances by the current increment modulo 2^20.
- R5: The first crossing after the hold only aligns the oscillator. The search starts with the increment at 2048. At each of the next twelve crossings it settles one bit, from bit 11 down to bit 0. The bit under test is cleared if the accumulator wrapped at least once since the previous crossing, and the next lower bit is set for trial.
- R6: For a reference period of T clocks, the search ends with the increment equal to min(4095, floor((2^20-1)/(T-1))).
- R7: locked rises at the edge of the thirteenth crossing after the hold and stays high until the next start.
- R8: After lock, at each crossing the increment is incremented if phase is at or above 2^19 and decremented otherwise. It saturates at 4095 and at 0.
- R9: done is high for exactly one clock, following the cap_len-th edge after the start edge (a cap_len of 0 acts as 1). At that edge cap_phase takes the phase value held in the clock before.
- R10: A start pulse at any time restarts the block: locked clears and phase returns to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one reference sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a measurement: hold, search, track and capture |
| ref_in | input | 12 | Signed filtered beat-frequency sample |
| hold_len | input | 16 | Hold interval in clocks, minus one |
| cap_len | input | 16 | Clocks from start to the phase snapshot |
| phase | output | 20 | Oscillator phase accumulator |
| locked | output | 1 | Search finished, fine tracking active |
| cap_phase | output | 20 | Phase snapshot taken at the capture strobe |
| done | output | 1 | One-clock capture strobe |

## Verification
Reference periods of 200, 400, 1000 and 1500 clocks drive the search to four different codes, including the top of the window. A search that took the wrong bit order or counted wraps over the wrong span would settle on a different code. Starting the count one crossing early would raise locked a period too soon. A fast full-swing wave played during the hold catches a loop that listens too early. A dip to -63 followed by one to -64 sits on both sides of the hysteresis threshold. The first tracking step after lock shows whether lead and lag are swapped. The capture strobe is checked one clock either side of its due edge and with a zero interval, and an off-by-one timer or a stale snapshot would show up there.

// File: rtl/sar_pll_pkg.sv
// Shared types for the successive-approximation phase estimator.
package sar_pll_pkg;
    // Measurement sequence: idle after reset, transient hold, loop running.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_pll_edge_det.sv
// Reference rising-crossing detector with a hysteresis arm threshold.
// Assumes: one signed sample per clock. A crossing is reported in the same
// cycle as the first non-negative sample after an arming sample (<= -HYST).
// While the loop is not running the detector is disarmed.
module sar_pll_edge_det #(
    parameter int SMP_W = 12,
    parameter int HYST  = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic signed [SMP_W-1:0] ref_in,
    output logic                    ref_edge
);
    localparam int                    ARM_TH_I = -HYST;
    localparam logic signed [SMP_W-1:0] ARM_TH = ARM_TH_I[SMP_W-1:0];

    logic armed;

    assign ref_edge = run && armed && !ref_in[SMP_W-1];

    // Arm on a deep negative sample, disarm on a reported crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!run) begin
            armed <= 1'b0;
        end else if (ref_in <= ARM_TH) begin
            armed <= 1'b1;
        end else if (ref_edge) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_pll_dco.sv
// Phase accumulator oscillator with a saturating wrap counter.
// Assumes: delta is held stable by the tuner; a crossing clears both the
// accumulator and the wrap count so each period is measured from zero.
module sar_pll_dco #(
    parameter int PHASE_W = 20,
    parameter int WRAP_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic               ref_edge,
    input  logic [PHASE_W-1:0] delta,
    output logic [PHASE_W-1:0] phase,
    output logic [WRAP_W-1:0]  wrap_cnt
);
    localparam logic [WRAP_W-1:0] WRAP_MAX = {WRAP_W{1'b1}};
    localparam logic [WRAP_W-1:0] WRAP_ONE = WRAP_W'(1);

    logic [PHASE_W:0] sum;

    assign sum = {1'b0, phase} + {1'b0, delta};

    // Advance the accumulator, clear on crossings, count wraps per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            wrap_cnt <= '0;
        end else if (!run || restart || ref_edge) begin
            phase    <= '0;
            wrap_cnt <= '0;
        end else begin
            phase <= sum[PHASE_W-1:0];
            if (sum[PHASE_W] && (wrap_cnt != WRAP_MAX)) begin
                wrap_cnt <= wrap_cnt + WRAP_ONE;
            end
        end
    end
endmodule

// File: rtl/sar_pll_tuner.sv
// Increment tuner: one alignment crossing, then a CODE_W-step binary search
// (MSB first) driven by a zero comparator on the wrap count, then +/-1 tracking
// from the accumulator MSB at each crossing, saturating at both window ends.
// Assumes: wrap_cnt and phase_msb reflect the period that ends at ref_edge.
module sar_pll_tuner #(
    parameter int CODE_W = 12,
    parameter int WRAP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              ref_edge,
    input  logic [WRAP_W-1:0] wrap_cnt,
    input  logic              phase_msb,
    output logic [CODE_W-1:0] code,
    output logic              locked
);
    localparam int                IDX_W    = $clog2(CODE_W);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_ONE << (CODE_W - 1);
    localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(CODE_W - 1);
    localparam logic [IDX_W-1:0]  IDX_ONE  = IDX_W'(1);

    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  bit_dn;
    logic [CODE_W-1:0] trial_code;
    logic              synced;
    logic              too_fast;

    assign too_fast = (wrap_cnt != '0);
    assign bit_dn   = bit_idx - IDX_ONE;

    // Settle the bit under test and raise the next lower trial bit.
    always_comb begin
        trial_code = code;
        if (too_fast) begin
            trial_code[bit_idx] = 1'b0;
        end
        if (bit_idx != '0) begin
            trial_code[bit_dn] = 1'b1;
        end
    end

    // Search/track sequencing, one decision per reference crossing.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            code    <= CODE_MID;
            bit_idx <= IDX_TOP;
            synced  <= 1'b0;
            locked  <= 1'b0;
        end else if (run && ref_edge) begin
            if (!synced) begin
                synced <= 1'b1;
            end else if (!locked) begin
                code <= trial_code;
                if (bit_idx == '0) begin
                    locked <= 1'b1;
                end else begin
                    bit_idx <= bit_dn;
                end
            end else if (phase_msb) begin
                if (code != CODE_MAX) begin
                    code <= code + CODE_ONE;
                end
            end else if (code != '0) begin
                code <= code - CODE_ONE;
            end
        end
    end
endmodule

// File: rtl/sar_pll_seq.sv
// Measurement sequencer: transient hold timer gating the loop, and a capture
// timer that snapshots the phase and pulses done once per start.
// Assumes: start is a single-cycle pulse; a new start restarts both timers.
module sar_pll_seq #(
    parameter int PHASE_W = 20,
    parameter int HOLD_W  = 16,
    parameter int CAP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [HOLD_W-1:0]  hold_len,
    input  logic [CAP_W-1:0]   cap_len,
    input  logic [PHASE_W-1:0] phase,
    output logic               loop_run,
    output logic [PHASE_W-1:0] cap_phase,
    output logic               done
);
    import sar_pll_pkg::*;

    localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);
    localparam logic [CAP_W-1:0]  CAP_ONE  = CAP_W'(1);

    seq_state_t        state;
    logic [HOLD_W-1:0] hold_cnt;
    logic [CAP_W-1:0]  cap_cnt;
    logic              cap_run;

    assign loop_run = (state == SEQ_RUN);

    // Hold timer: keep the loop idle for hold_len+1 edges after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            hold_cnt <= '0;
        end else if (start) begin
            state    <= SEQ_HOLD;
            hold_cnt <= hold_len;
        end else if (state == SEQ_HOLD) begin
            if (hold_cnt == '0) begin
                state <= SEQ_RUN;
            end else begin
                hold_cnt <= hold_cnt - HOLD_ONE;
            end
        end
    end

    // Capture timer: snapshot phase and strobe done at the cap_len-th edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cnt   <= '0;
            cap_run   <= 1'b0;
            cap_phase <= '0;
            done      <= 1'b0;
        end else if (start) begin
            cap_cnt <= cap_len;
            cap_run <= 1'b1;
            done    <= 1'b0;
        end else if (cap_run && (cap_cnt <= CAP_ONE)) begin
            cap_phase <= phase;
            cap_run   <= 1'b0;
            done      <= 1'b1;
        end else begin
            done <= 1'b0;
            if (cap_run) begin
                cap_cnt <= cap_cnt - CAP_ONE;
            end
        end
    end
endmodule

// File: rtl/sar_pll_phase_est.sv
// Top: beat-frequency phase estimator. Joins the sequencer, the crossing
// detector, the accumulator oscillator and the increment tuner.
// Assumes: the reference is already band-limited around the beat tone.
module sar_pll_phase_est #(
    parameter int PHASE_W = 20,
    parameter int CODE_W  = 12,
    parameter int SMP_W   = 12,
    parameter int HYST    = 64,
    parameter int HOLD_W  = 16,
    parameter int CAP_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [SMP_W-1:0] ref_in,
    input  logic [HOLD_W-1:0]       hold_len,
    input  logic [CAP_W-1:0]        cap_len,
    output logic [PHASE_W-1:0]      phase,
    output logic                    locked,
    output logic [PHASE_W-1:0]      cap_phase,
    output logic                    done
);
    localparam int WRAP_W = 2;

    logic               loop_run;
    logic               ref_edge;
    logic [WRAP_W-1:0]  wrap_cnt;
    logic [CODE_W-1:0]  code;
    logic [PHASE_W-1:0] delta;

    assign delta = {{(PHASE_W - CODE_W){1'b0}}, code};

    sar_pll_seq #(.PHASE_W(PHASE_W), .HOLD_W(HOLD_W), .CAP_W(CAP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .hold_len(hold_len),
        .cap_len(cap_len), .phase(phase), .loop_run(loop_run),
        .cap_phase(cap_phase), .done(done)
    );

    sar_pll_edge_det #(.SMP_W(SMP_W), .HYST(HYST)) u_edge (
        .clk(clk), .rst_n(rst_n), .run(loop_run), .ref_in(ref_in),
        .ref_edge(ref_edge)
    );

    sar_pll_dco #(.PHASE_W(PHASE_W), .WRAP_W(WRAP_W)) u_dco (
        .clk(clk), .rst_n(rst_n), .run(loop_run), .restart(start),
        .ref_edge(ref_edge), .delta(delta), .phase(phase), .wrap_cnt(wrap_cnt)
    );

    sar_pll_tuner #(.CODE_W(CODE_W), .WRAP_W(WRAP_W)) u_tune (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(loop_run),
        .ref_edge(ref_edge), .wrap_cnt(wrap_cnt), .phase_msb(phase[PHASE_W-1]),
        .code(code), .locked(locked)
    );
endmodule

// File: rtl/sar_pll_checker.sv
// Temporal checks on the phase estimator, bound into every instance of the top.
// Assumes: signals are sampled on the rising clock edge with synchronous reset.
module sar_pll_checker #(
    parameter int PHASE_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               ref_edge,
    input logic               loop_run,
    input logic [PHASE_W-1:0] phase,
    input logic [PHASE_W-1:0] delta,
    input logic               locked,
    input logic               done,
    input logic [PHASE_W-1:0] cap_phase
);
    // R2: accumulator parked at zero whenever the loop is gated off.
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_run |-> phase == '0);

    // R4: free-running step between crossings.
    p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loop_run) && !$past(ref_edge) && !$past(start))
        |-> phase == PHASE_W'($past(phase) + $past(delta)));

    // R4: crossing clears the accumulator.
    p_edge_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> phase == '0);

    // R8: tracking moves the increment by at most one count per clock.
    p_track_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |->
        (delta == $past(delta) || delta == $past(delta) + 1 ||
         delta + 1 == $past(delta)));

    // R9: done is a single-cycle strobe.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: snapshot equals the phase of the preceding clock.
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> cap_phase == $past(phase));

    // R10: start drops lock on the next edge.
    p_lock_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !locked);
endmodule

bind sar_pll_phase_est sar_pll_checker #(.PHASE_W(PHASE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_edge(ref_edge),
    .loop_run(loop_run), .phase(phase), .delta(delta), .locked(locked),
    .done(done), .cap_phase(cap_phase)
);

// File: tb/sar_pll_phase_est_test.sv
module sar_pll_phase_est_test;
    localparam int PW  = 20;
    localparam int MOD = 1 << PW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [11:0] ref_in = '0;
    logic [15:0]       hold_len = '0;
    logic [15:0]       cap_len = '0;
    logic [PW-1:0]     phase;
    logic              locked;
    logic [PW-1:0]     cap_phase;
    logic              done;

    int n_chk = 0;
    int n_err = 0;

    // Vectors: reference period in clocks, expected final search code (R6).
    localparam int VEC [4][2] = '{'{1000, 1049}, '{400, 2628},
                                  '{200, 4095}, '{1500, 699}};

    sar_pll_phase_est uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_in(ref_in),
        .hold_len(hold_len), .cap_len(cap_len), .phase(phase),
        .locked(locked), .cap_phase(cap_phase), .done(done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act,
                       input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one sample (and start) for one clock, then settle past the edge.
    task automatic tick(input int s, input bit st);
        ref_in = s[11:0];
        start  = st;
        @(posedge clk);
        #2;
        start = 1'b0;
    endtask

    function automatic int wave(input int t, input int per);
        return ((t % per) < per / 2) ? -1000 : 1000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R1: reset state.
        chk(phase == '0, "R1 phase", phase, 0);
        chk(locked == 1'b0, "R1 locked", locked, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(cap_phase == '0, "R1 cap_phase", cap_phase, 0);
        rst_n = 1'b1;
        tick(0, 0);

        // Table-driven search and first tracking step.
        for (int v = 0; v < 4; v++) begin
            int per;
            int expc;
            int t13;
            int t14;
            int ph_edge;
            int exp_trk;
            bit hold_ok;
            per  = VEC[v][0];
            expc = VEC[v][1];
            hold_len = 16'd20;
            cap_len  = 16'hFFFF;
            tick(0, 1);
            chk(locked == 1'b0, "R10 lock cleared by start", locked, 0);
            chk(phase == '0, "R2 phase after start", phase, 0);
            hold_ok = 1'b1;
            for (int h = 0; h < 21; h++) begin
                tick(((h % 10) < 5) ? -1000 : 1000, 0);
                if (phase != '0) hold_ok = 1'b0;
            end
            chk(hold_ok, "R2 hold ignores samples", hold_ok, 1);
            t13 = per / 2 + 12 * per;
            t14 = t13 + per;
            for (int t = 0; t <= t13; t++) begin
                if (t == t13) chk(locked == 1'b0, "R7 not locked before 13th crossing", locked, 0);
                tick(wave(t, per), 0);
            end
            chk(locked == 1'b1, "R7 locked at 13th crossing", locked, 1);
            tick(wave(t13 + 1, per), 0);
            chk(phase == PW'(expc), "R5 R6 search code", phase, expc);
            for (int t = t13 + 2; t < t14; t++) tick(wave(t, per), 0);
            ph_edge = int'((longint'(per - 1) * expc) % MOD);
            chk(phase == PW'(ph_edge), "R4 phase at crossing", phase, ph_edge);
            if (ph_edge >= MOD / 2) exp_trk = (expc < 4095) ? expc + 1 : 4095;
            else exp_trk = (expc > 0) ? expc - 1 : 0;
            tick(wave(t14, per), 0);
            tick(wave(t14 + 1, per), 0);
            chk(phase == PW'(exp_trk), "R8 tracking step", phase, exp_trk);
        end

        // Hysteresis threshold and free-run wrap.
        hold_len = 16'd5;
        cap_len  = 16'hFFFF;
        tick(0, 1);
        for (int h = 0; h < 6; h++) tick(-1000, 0);
        for (int i = 0; i < 100; i++) tick(((i % 2) == 0) ? -63 : 500, 0);
        chk(phase == PW'(204800), "R3 shallow dip does not arm", phase, 204800);
        tick(-64, 0);
        chk(phase == PW'(206848), "R3 arming sample no crossing", phase, 206848);
        tick(0, 0);
        chk(phase == '0, "R3 zero sample is a crossing", phase, 0);
        for (int i = 0; i < 600; i++) tick(500, 0);
        chk(phase == PW'(180224), "R4 modulo wrap", phase, 180224);

        // Capture timing and snapshot.
        begin
            logic [PW-1:0] prev_ph;
            hold_len = 16'd3;
            cap_len  = 16'd40;
            prev_ph  = '0;
            tick(0, 1);
            for (int i = 1; i <= 41; i++) begin
                if (i == 40) prev_ph = phase;
                tick(wave(i - 1, 60), 0);
                if (i == 39) chk(done == 1'b0, "R9 done not early", done, 0);
                if (i == 40) begin
                    chk(done == 1'b1, "R9 done on time", done, 1);
                    chk(cap_phase == prev_ph, "R9 snapshot", cap_phase, prev_ph);
                    chk(prev_ph != '0, "R9 snapshot nontrivial", prev_ph, 1);
                end
                if (i == 41) chk(done == 1'b0, "R9 done one clock", done, 0);
            end
            cap_len = 16'd0;
            tick(0, 1);
            tick(0, 0);
            chk(done == 1'b1, "R9 zero interval acts as one", done, 1);
            tick(0, 0);
            chk(done == 1'b0, "R9 zero interval single pulse", done, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule